// File: doc/BRIEF.md
# Loop Status Deglitch and Battery-Select Timer

This block takes the raw, active-low loop-closure status from a subscriber line interface and turns it into a clean hook state. The raw pin is never used directly. It is synchronised into the clock domain and sampled once per 1 ms tick. A change reaches the filtered hook output only after it has held for a programmable number of consecutive samples.

Every commanded control-state change briefly corrupts the status. A battery reversal can fake about 50 ms of loop current, and entering or leaving ring mode produces a pulse whose width depends on the ringing phase. To cover this, the block opens a blanking window, counted in 1 ms ticks, on each transition event and on each edge of the ring-active flag. While the window is open, the filtered state is frozen. The intended window setting is 60 ms.

Once off-hook is confirmed, a fixed hold-off must run uninterrupted before the low-voltage battery is selected. Any on-hook sample seen while waiting restarts the hold-off, so a dial-pulse string never causes a battery switch. Confirmed on-hook, and any ringing, keep or return the line on high battery.

Top module: `loop_supervisor`

## Requirements
- R1: After reset, `hook_off`, `offhook_evt` and `batt_low` are all 0.
- R2: `stat_n` low means loop closed (off-hook). It passes through a `SYNC_STAGES`-flop synchroniser and is sampled only on cycles where `tick_1ms` is 1. Between ticks, `hook_off` does not change.
- R3: Outside blanking, `hook_off` takes a new value only on the `persist_n`-th consecutive sample that differs from it. A sample that agrees with `hook_off` clears the run. A `persist_n` of 0 acts as 1.
- R4: A `xition_pulse` loads the window with `blank_ms`. The next `blank_ms` ticks are ignored, `hook_off` stays frozen and the persistence run is cleared. A `blank_ms` of 0 disables blanking.
- R5: Every rising or falling edge of `ring_on` opens the same blanking window as `xition_pulse`.
- R6: `offhook_evt` is a one-cycle pulse in the cycle where `hook_off` rises. It never pulses when `hook_off` falls.
- R7: `batt_low` rises on the `HOLD_MS`-th tick after the tick that confirmed off-hook, provided off-hook and no ringing hold throughout.
- R8: Before `batt_low` has risen, any unblanked tick sample showing on-hook restarts the hold-off. `batt_low` then rises on the `HOLD_MS`-th tick after that sample.
- R9: `batt_low` falls in the same cycle as `hook_off` falls.
- R10: While `ring_on` is 1, `batt_low` is 0 and the hold-off is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stat_n | input | 1 | Raw loop status, low = loop closed |
| xition_pulse | input | 1 | One-cycle pulse on any commanded state change |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| ring_on | input | 1 | Ring mode active |
| blank_ms | input | BLANK_W | Blanking window length in ticks |
| persist_n | input | PERSIST_W | Consecutive samples needed to accept a change |
| hook_off | output | 1 | Filtered hook state, 1 = off-hook |
| offhook_evt | output | 1 | One-cycle pulse on confirmed off-hook |
| batt_low | output | 1 | Select low-voltage battery |

## Verification
The bench interrupts a persistence run one sample short, so a filter that keeps counting instead of restarting would accept the change early. It places a status change inside a blanking window and checks the acceptance tick exactly, which catches a window that is one tick short, ignored, or that lets the run count survive. It injects a single on-hook sample deep into the hold-off and checks that `batt_low` is a full `HOLD_MS` ticks late; a timer that only restarts on a confirmed on-hook would switch during dialling. Ring-active and release-to-on-hook cases check that the battery select is forced high at once rather than on the next tick.

// File: rtl/lsup_pkg.sv
package lsup_pkg;
  typedef enum logic {
    HOOK_ON  = 1'b0,
    HOOK_OFF = 1'b1
  } hook_e;
endpackage

// File: rtl/lsup_sync.sv
module lsup_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= {STAGES{RST_VAL}};
    end else begin
      sh[0] <= d;
      for (int i = 1; i < STAGES; i++) sh[i] <= sh[i-1];
    end
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/lsup_blanker.sv
module lsup_blanker #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start,
  input  logic [BW-1:0] len,
  output logic          blank
);
  logic [BW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (start)              cnt <= len;
    else if (tick && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign blank = (cnt != '0);

  // R4: a transition with a nonzero length opens the window next cycle
  assert_blank_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && len != '0) |=> blank);

  // R4: without a tick or a new start the window does not move
  assert_blank_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !tick) |=> $stable(cnt));
endmodule

// File: rtl/lsup_debounce.sv
module lsup_debounce
  import lsup_pkg::*;
#(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          blank,
  input  logic          raw_off,
  input  logic [PW-1:0] persist,
  output logic          hook,
  output logic          rise_evt,
  output logic          brk
);
  hook_e         state;
  logic [PW-1:0] run;
  logic [PW:0]   run_nxt;
  logic [PW:0]   need;

  assign run_nxt = {1'b0, run} + 1'b1;
  assign need    = (persist == '0) ? {{PW{1'b0}}, 1'b1} : {1'b0, persist};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= HOOK_ON;
      run      <= '0;
      rise_evt <= 1'b0;
    end else begin
      rise_evt <= 1'b0;
      if (tick) begin
        if (blank) begin
          run <= '0;
        end else if (raw_off != logic'(state)) begin
          if (run_nxt >= need) begin
            state    <= hook_e'(raw_off);
            run      <= '0;
            rise_evt <= raw_off;
          end else begin
            run <= run_nxt[PW-1:0];
          end
        end else begin
          run <= '0;
        end
      end
    end
  end

  assign hook = (state == HOOK_OFF);
  assign brk  = tick && !blank && !raw_off;

  // R2/R3: the filtered state moves only on an unblanked tick
  assert_hook_moves_on_open_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hook) |-> $past(tick && !blank));

  // R6: the event is a single-cycle pulse
  assert_evt_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> !rise_evt);

  // R6: the event pulses only with off-hook asserted
  assert_evt_with_hook_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |-> hook);
endmodule

// File: rtl/lsup_batt_timer.sv
module lsup_batt_timer #(
  parameter int HOLD_MS = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hook,
  input  logic ring,
  input  logic brk,
  output logic batt_low
);
  localparam int CW = $clog2(HOLD_MS + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_MS - 1);

  logic [CW-1:0] cnt;
  logic          armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (!hook || ring) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (tick && !armed) begin
      if (brk) begin
        cnt <= '0;
      end else if (cnt == LAST) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign batt_low = armed && hook && !ring;

  // R9: low battery only while off-hook
  assert_batt_needs_hook_R9: assert property (@(posedge clk) disable iff (!rst_n)
    batt_low |-> hook);

  // R10: ringing keeps high battery
  assert_ring_keeps_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ring |-> !batt_low);

  // R7: the low-battery select rises only after a tick
  assert_batt_rises_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(tick));
endmodule

// File: rtl/loop_supervisor.sv
module loop_supervisor #(
  parameter int BLANK_W     = 8,
  parameter int PERSIST_W   = 4,
  parameter int HOLD_MS     = 500,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 stat_n,
  input  logic                 xition_pulse,
  input  logic                 tick_1ms,
  input  logic                 ring_on,
  input  logic [BLANK_W-1:0]   blank_ms,
  input  logic [PERSIST_W-1:0] persist_n,
  output logic                 hook_off,
  output logic                 offhook_evt,
  output logic                 batt_low
);
  logic stat_s;
  logic ring_q;
  logic ring_edge;
  logic blank_start;
  logic blanking;
  logic brk;

  lsup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(stat_n), .q(stat_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ring_q <= 1'b0;
    else        ring_q <= ring_on;
  end

  assign ring_edge   = ring_on ^ ring_q;
  assign blank_start = xition_pulse || ring_edge;

  lsup_blanker #(.BW(BLANK_W)) u_blank (
    .clk(clk), .rst_n(rst_n), .tick(tick_1ms), .start(blank_start),
    .len(blank_ms), .blank(blanking)
  );

  lsup_debounce #(.PW(PERSIST_W)) u_deb (
    .clk(clk), .rst_n(rst_n), .tick(tick_1ms), .blank(blanking),
    .raw_off(!stat_s), .persist(persist_n), .hook(hook_off),
    .rise_evt(offhook_evt), .brk(brk)
  );

  lsup_batt_timer #(.HOLD_MS(HOLD_MS)) u_batt (
    .clk(clk), .rst_n(rst_n), .tick(tick_1ms), .hook(hook_off),
    .ring(ring_on), .brk(brk), .batt_low(batt_low)
  );

  // R5: a ring edge opens the window when a length is set
  assert_ring_edge_blanks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_edge && blank_ms != '0) |=> blanking);

  // R9: confirmed on-hook drops the low-battery select in the same cycle
  assert_onhook_drops_batt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hook_off) |-> !batt_low);
endmodule

// File: tb/test_loop_supervisor.sv
module test_loop_supervisor;
  localparam int HOLD = 500;
  localparam int BLK  = 5;
  localparam int PER  = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stat_n = 1'b1;
  logic       xition_pulse = 1'b0;
  logic       tick_1ms = 1'b0;
  logic       ring_on = 1'b0;
  logic [7:0] blank_ms = 8'(BLK);
  logic [3:0] persist_n = 4'(PER);
  logic       hook_off, offhook_evt, batt_low;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  loop_supervisor #(.HOLD_MS(HOLD)) i_loop_supervisor (
    .clk(clk), .rst_n(rst_n), .stat_n(stat_n), .xition_pulse(xition_pulse),
    .tick_1ms(tick_1ms), .ring_on(ring_on), .blank_ms(blank_ms),
    .persist_n(persist_n), .hook_off(hook_off), .offhook_evt(offhook_evt),
    .batt_low(batt_low)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_1ms = 1'b1;
      @(negedge clk) tick_1ms = 1'b0;
    end
  endtask

  task automatic set_line(input logic v);
    @(negedge clk) stat_n = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_xition();
    @(negedge clk) xition_pulse = 1'b1;
    @(negedge clk) xition_pulse = 1'b0;
  endtask

  task automatic set_ring(input logic v);
    @(negedge clk) ring_on = v;
    repeat (2) @(negedge clk);
  endtask

  task automatic go_onhook();
    set_line(1'b1);
    ticks(PER);
  endtask

  task automatic t_reset();
    check("R1 hook_off", hook_off, 1'b0);
    check("R1 offhook_evt", offhook_evt, 1'b0);
    check("R1 batt_low", batt_low, 1'b0);
  endtask

  task automatic t_persist();
    set_line(1'b0);
    repeat (20) @(negedge clk);
    check("R2 no tick no change", hook_off, 1'b0);
    ticks(PER - 1);
    check("R3 short run held", hook_off, 1'b0);
    ticks(1);
    check("R3 accepted", hook_off, 1'b1);
    check("R6 evt on rise", offhook_evt, 1'b1);
    @(negedge clk);
    check("R6 evt one cycle", offhook_evt, 1'b0);
    set_line(1'b1);
    ticks(PER - 1);
    check("R3 on-hook short run", hook_off, 1'b1);
    ticks(1);
    check("R3 on-hook accepted", hook_off, 1'b0);
    check("R6 no evt on fall", offhook_evt, 1'b0);
  endtask

  task automatic t_interrupt();
    set_line(1'b0);
    ticks(PER - 1);
    set_line(1'b1);
    ticks(1);
    set_line(1'b0);
    ticks(PER - 1);
    check("R3 run restarted", hook_off, 1'b0);
    ticks(1);
    check("R3 restarted run accepted", hook_off, 1'b1);
    go_onhook();
  endtask

  task automatic t_blank();
    pulse_xition();
    set_line(1'b0);
    ticks(BLK + PER - 1);
    check("R4 window ignored samples", hook_off, 1'b0);
    ticks(1);
    check("R4 accepted after window", hook_off, 1'b1);
    pulse_xition();
    set_line(1'b1);
    ticks(BLK);
    check("R4 frozen off-hook", hook_off, 1'b1);
    set_line(1'b0);
    ticks(2);
    go_onhook();
    blank_ms = 8'd0;
    pulse_xition();
    set_line(1'b0);
    ticks(PER);
    check("R4 zero length no window", hook_off, 1'b1);
    blank_ms = 8'(BLK);
    go_onhook();
  endtask

  task automatic t_ring();
    set_ring(1'b1);
    set_line(1'b0);
    ticks(BLK + PER - 1);
    check("R5 ring edge blanks", hook_off, 1'b0);
    ticks(1);
    check("R5 accepted after ring window", hook_off, 1'b1);
    ticks(HOLD + 10);
    check("R10 ring keeps high battery", batt_low, 1'b0);
    set_ring(1'b0);
    ticks(HOLD - 1);
    check("R10 hold-off starts after ring", batt_low, 1'b0);
    ticks(1);
    check("R10 low after ring ends", batt_low, 1'b1);
    set_ring(1'b1);
    check("R10 ring forces high at once", batt_low, 1'b0);
    set_ring(1'b0);
    ticks(BLK);
    go_onhook();
  endtask

  task automatic t_hold();
    set_line(1'b0);
    ticks(PER);
    check("R7 confirmed", hook_off, 1'b1);
    ticks(HOLD - 1);
    check("R7 not yet low", batt_low, 1'b0);
    ticks(1);
    check("R7 low at hold-off", batt_low, 1'b1);
  endtask

  task automatic t_onhook();
    set_line(1'b1);
    ticks(PER - 1);
    check("R9 still low before release", batt_low, 1'b1);
    ticks(1);
    check("R9 hook fell", hook_off, 1'b0);
    check("R9 high with release", batt_low, 1'b0);
  endtask

  task automatic t_break();
    set_line(1'b0);
    ticks(PER);
    ticks(100);
    set_line(1'b1);
    ticks(1);
    set_line(1'b0);
    check("R8 hook kept through break", hook_off, 1'b1);
    ticks(HOLD - 1);
    check("R8 hold-off restarted", batt_low, 1'b0);
    ticks(1);
    check("R8 low after restart", batt_low, 1'b1);
    go_onhook();
  endtask

  task automatic t_persist0();
    persist_n = 4'd0;
    set_line(1'b0);
    ticks(1);
    check("R3 zero persist acts as one", hook_off, 1'b1);
    persist_n = 4'(PER);
    go_onhook();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_persist();
    t_interrupt();
    t_blank();
    t_ring();
    t_hold();
    t_onhook();
    t_break();
    t_persist0();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule